// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Deferred Disable

This block serialises characters onto an asynchronous serial line. Software writes a character into a one-deep holding register. The character moves into a shift register as soon as the shifter is free. The shifter then sends a low start bit, 8 data bits least significant bit first, an optional ninth data bit and a high stop bit. Each bit lasts a fixed number of baud ticks, and the ticks come from an external rate generator.

Two flags report progress. The empty flag shows that the holding register can accept another character. The done flag shows that the line has gone quiet with nothing waiting. Each flag drives an interrupt request, gated by its own enable and by a global enable.

Clearing the transmitter enable never cuts a character short. The character already shifting and a character still waiting in the holding register both go out before the transmitter stops. After that, a newly written character is held until the enable is set again.

Top module: `sertx_deferred`

## Requirements
- R1: After reset, txd is 1, flag_empty is 1, flag_done is 0, and both interrupt requests are 0.
- R2: Frame format and idle level:
  - A frame is one low start bit, then wr_data bit 0 through bit 7 in that order, then one high stop bit.
  - Every bit lasts TICKS_PER_BIT (16) baud ticks.
  - txd is 1 whenever no frame is being sent.
- R3: When mode9 is 1 at the moment a character enters the shifter, the value of wr_bit9 captured with that write is sent as an extra data bit after data bit 7 and before the stop bit.
- R4: Transfer to the shifter and back-to-back sending:
  - A write sets flag_empty to 0.
  - A character held while the shifter is idle or finishing its stop bit is transferred, and flag_empty returns to 1 on that transfer.
  - Characters written while the previous one is shifting follow it with no idle time: start bits are exactly one frame length apart.
- R5: Clearing tx_en while a frame is in flight still completes that frame and the character waiting in the holding register.
- R6: With tx_en at 0 and the transmitter drained, a written character stays held. txd stays 1 and flag_empty stays 0. The character is sent once tx_en returns to 1.
- R7: flag_done becomes 1 when a stop bit ends with no character waiting. It stays 0 between back-to-back characters.
- R8: flag_done is cleared by a data write or by a one-cycle pulse on done_clr.
- R9: irq_empty equals flag_empty AND ie_empty AND gie.
- R10: irq_done equals flag_done AND ie_done AND gie.
- R11: Bit timing counts baud ticks, not clocks. With one tick every three clocks, a frame lasts three times as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud tick (TICKS_PER_BIT ticks per bit) |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Character written with wr_en |
| wr_bit9 | input | 1 | Ninth data bit, captured with wr_en |
| mode9 | input | 1 | 1 selects nine data bits |
| tx_en | input | 1 | Transmitter enable |
| ie_empty | input | 1 | Enable for the empty interrupt request |
| ie_done | input | 1 | Enable for the done interrupt request |
| gie | input | 1 | Global interrupt enable |
| done_clr | input | 1 | Write-one pulse clearing flag_done |
| txd | output | 1 | Serial line |
| flag_empty | output | 1 | Holding register empty |
| flag_done | output | 1 | Transmission complete |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
Every one of the 256 byte values is sent in 8-bit mode, each one written while its predecessor is still shifting. A wrong bit order, a stuck data bit or an extra idle gap between frames shows up there. A sweep of 9-bit frames pairs 32 byte values with both ninth-bit values, which separates the ninth bit from the stop bit. A run with a sparse tick shows whether bit length follows ticks or clocks. A sequence that writes two characters and then drops the enable, followed by a write while disabled, tells deferred shutdown apart from both an immediate stop and a transmitter that ignores the enable.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   localparam int unsigned SERTX_DATA_W_DEF = 8;
   localparam int unsigned SERTX_TPB_DEF    = 16;

   // number of bit slots in a frame: start + data + optional ninth + stop
   function automatic int unsigned sertx_frame_len(input int unsigned dw, input bit nine);
      return dw + 2 + (nine ? 1 : 0);
   endfunction

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              take,
   output logic [DATA_W-1:0] q_data,
   output logic              q_bit9,
   output logic              full
);

   logic [DATA_W-1:0] data_q;
   logic              bit9_q;
   logic              full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         bit9_q <= 1'b0;
      end else if (wr_en) begin
         data_q <= wr_data;
         bit9_q <= wr_bit9;
      end
   end

   // a write in the same cycle as a transfer refills the register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       full_q <= 1'b0;
      else if (wr_en)   full_q <= 1'b1;
      else if (take)    full_q <= 1'b0;
   end

   assign q_data = data_q;
   assign q_bit9 = bit9_q;
   assign full   = full_q;

   assert_write_fills_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full_q);
   assert_take_needs_full_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_q);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned TPB     = 16,
   parameter bit          NINE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_bit9,
   input  logic              ld_mode9,
   output logic              txd,
   output logic              busy,
   output logic              done_pulse
);

   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned CNT_W   = (TPB > 1) ? $clog2(TPB) : 1;
   localparam int unsigned LEFT_W  = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(TPB - 1);
   localparam logic [LEFT_W-1:0] LEN_8    = LEFT_W'(sertx_pkg::sertx_frame_len(DATA_W, 1'b0));
   localparam logic [LEFT_W-1:0] LEN_9    = LEFT_W'(sertx_pkg::sertx_frame_len(DATA_W, 1'b1));
   localparam logic [LEFT_W-1:0] LEFT_ONE = LEFT_W'(1);

   logic [FRAME_W-1:0] shreg_q;
   logic [LEFT_W-1:0]  left_q;
   logic [CNT_W-1:0]   tcnt_q;
   logic               busy_q;
   logic               extra_bit;
   logic [LEFT_W-1:0]  load_len;
   logic               bit_end;

   generate
      if (NINE_EN) begin : g_nine
         assign extra_bit = ld_mode9 ? ld_bit9 : 1'b1;
         assign load_len  = ld_mode9 ? LEN_9 : LEN_8;
      end else begin : g_eight
         logic unused_nine;
         assign unused_nine = ld_mode9 ^ ld_bit9;
         assign extra_bit   = 1'b1;
         assign load_len    = LEN_8;
      end
   endgenerate

   assign bit_end    = busy_q && tick && (tcnt_q == CNT_LAST);
   assign done_pulse = bit_end && (left_q == LEFT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         left_q  <= '0;
         tcnt_q  <= '0;
         busy_q  <= 1'b0;
      end else if (load) begin
         shreg_q <= {1'b1, extra_bit, ld_data, 1'b0};
         left_q  <= load_len;
         tcnt_q  <= '0;
         busy_q  <= 1'b1;
      end else if (bit_end) begin
         shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
         left_q  <= left_q - LEFT_ONE;
         tcnt_q  <= '0;
         if (left_q == LEFT_ONE) busy_q <= 1'b0;
      end else if (busy_q && tick) begin
         tcnt_q  <= tcnt_q + CNT_W'(1);
      end
   end

   assign txd  = busy_q ? shreg_q[0] : 1'b1;
   assign busy = busy_q;

   assert_start_low_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (txd == 1'b0));
   assert_bit_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick && !load) |=> $stable(txd));

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic done_pulse,
   input  logic hold_full,
   input  logic done_clr,
   input  logic ie_empty,
   input  logic ie_done,
   input  logic gie,
   output logic flag_empty,
   output logic flag_done,
   output logic irq_empty,
   output logic irq_done
);

   logic done_q;

   // write clears first, a finishing stop bit sets next, then the clear pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        done_q <= 1'b0;
      else if (wr_en)                    done_q <= 1'b0;
      else if (done_pulse && !hold_full) done_q <= 1'b1;
      else if (done_clr)                 done_q <= 1'b0;
   end

   assign flag_empty = !hold_full;
   assign flag_done  = done_q;
   assign irq_empty  = flag_empty & ie_empty & gie;
   assign irq_done   = done_q & ie_done & gie;

   assert_done_sets_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && !hold_full && !wr_en) |=> done_q);
   assert_write_clears_done_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !done_q);

endmodule

// File: rtl/sertx_deferred.sv
module sertx_deferred #(
   parameter int unsigned DATA_W        = sertx_pkg::SERTX_DATA_W_DEF,
   parameter int unsigned TICKS_PER_BIT = sertx_pkg::SERTX_TPB_DEF,
   parameter bit          NINE_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_bit9,
   input  logic              mode9,
   input  logic              tx_en,
   input  logic              ie_empty,
   input  logic              ie_done,
   input  logic              gie,
   input  logic              done_clr,
   output logic              txd,
   output logic              flag_empty,
   output logic              flag_done,
   output logic              irq_empty,
   output logic              irq_done
);

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("sertx_deferred: DATA_W out of range 5..16");
      end
      if (TICKS_PER_BIT < 2) begin : g_bad_tpb
         $error("sertx_deferred: TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] hold_data;
   logic              hold_bit9;
   logic              hold_full;
   logic              sh_busy;
   logic              sh_done;
   logic              take;
   logic              active_q;

   // the shifter may reload on the cycle its last stop bit ends
   assign take = hold_full && (!sh_busy || sh_done) && (tx_en || active_q);

   // active stays up after tx_en falls until both stages are drained
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= tx_en || (active_q && (sh_busy || hold_full));
   end

   sertx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .wr_bit9 (wr_bit9),
      .take    (take),
      .q_data  (hold_data),
      .q_bit9  (hold_bit9),
      .full    (hold_full)
   );

   sertx_shifter #(.DATA_W(DATA_W), .TPB(TICKS_PER_BIT), .NINE_EN(NINE_EN)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .load       (take),
      .ld_data    (hold_data),
      .ld_bit9    (hold_bit9),
      .ld_mode9   (mode9),
      .txd        (txd),
      .busy       (sh_busy),
      .done_pulse (sh_done)
   );

   sertx_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .done_pulse (sh_done),
      .hold_full  (hold_full),
      .done_clr   (done_clr),
      .ie_empty   (ie_empty),
      .ie_done    (ie_done),
      .gie        (gie),
      .flag_empty (flag_empty),
      .flag_done  (flag_done),
      .irq_empty  (irq_empty),
      .irq_done   (irq_done)
   );

   assert_drain_pending_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && hold_full) |=> sh_busy);
   assert_stay_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !active_q && !sh_busy) |=> !sh_busy);

endmodule

// File: tb/test_sertx_deferred.sv
module test_sertx_deferred;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_bit9 = 1'b0;
   logic       mode9 = 1'b0;
   logic       tx_en = 1'b0;
   logic       ie_empty = 1'b0;
   logic       ie_done = 1'b0;
   logic       gie = 1'b0;
   logic       done_clr = 1'b0;
   logic       txd, flag_empty, flag_done, irq_empty, irq_done;

   int checks = 0;
   int errors = 0;
   longint cyc = 0;
   int tick_div = 1;
   int tick_cnt = 0;

   logic [8:0] exp_v  [0:63];
   bit         exp_m9 [0:63];
   int wr_idx = 0;
   int rx_count = 0;
   bit gap_chk_en = 0;
   bit have_prev = 0;
   longint prev_start = 0;
   int gap_ok = 0;
   int gap_bad = 0;
   bit watch_done = 0;
   bit done_seen = 0;

   always #10 clk = ~clk;

   sertx_deferred i_sertx_deferred (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .wr_bit9(wr_bit9), .mode9(mode9), .tx_en(tx_en),
      .ie_empty(ie_empty), .ie_done(ie_done), .gie(gie), .done_clr(done_clr),
      .txd(txd), .flag_empty(flag_empty), .flag_done(flag_done),
      .irq_empty(irq_empty), .irq_done(irq_done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (tick_cnt >= tick_div - 1) begin
         tick_cnt = 0;
         baud_tick = 1'b1;
      end else begin
         tick_cnt = tick_cnt + 1;
         baud_tick = 1'b0;
      end
      if (watch_done && flag_done) done_seen = 1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // serial receiver: samples mid-bit, compares with the expected queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            longint st;
            int nb;
            bit m9;
            logic [8:0] got;
            logic stopb;
            logic startb;
            int idx;
            st = cyc;
            idx = rx_count % 64;
            m9 = exp_m9[idx];
            nb = m9 ? 11 : 10;
            got = '0;
            repeat (8 * tick_div) @(negedge clk);
            startb = txd;
            for (int b = 0; b < (m9 ? 9 : 8); b++) begin
               repeat (16 * tick_div) @(negedge clk);
               got[b] = txd;
            end
            repeat (16 * tick_div) @(negedge clk);
            stopb = txd;
            if (!m9) got[8] = 1'b0;
            if (m9)
               chk(got == exp_v[idx] && startb == 1'b0 && stopb == 1'b1, "R3 nine-bit frame",
                   longint'({startb, stopb, got}), longint'({1'b0, 1'b1, exp_v[idx]}));
            else
               chk(got == exp_v[idx] && startb == 1'b0 && stopb == 1'b1, "R2 eight-bit frame",
                   longint'({startb, stopb, got}), longint'({1'b0, 1'b1, exp_v[idx]}));
            if (gap_chk_en) begin
               if (have_prev) begin
                  if (st - prev_start == longint'(nb * 16 * tick_div)) gap_ok++;
                  else begin
                     gap_bad++;
                     $display("FAIL R4 start spacing actual=%0d expected=%0d",
                              st - prev_start, nb * 16 * tick_div);
                  end
               end
               have_prev = 1;
               prev_start = st;
            end
            rx_count++;
         end
      end
   end

   task automatic write_char(input logic [7:0] d, input logic b9);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      wr_bit9 = b9;
      exp_v[wr_idx % 64] = mode9 ? {b9, d} : {1'b0, d};
      exp_m9[wr_idx % 64] = mode9;
      wr_idx++;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 2000; i++) begin
         if (flag_empty) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_rx(input int target);
      for (int i = 0; i < 4000; i++) begin
         if (rx_count >= target) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4000; i++) begin
         if (flag_done) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd idle", txd, 1);
      chk(flag_empty == 1'b1, "R1 flag_empty", flag_empty, 1);
      chk(flag_done == 1'b0, "R1 flag_done", flag_done, 0);
      chk(irq_empty == 1'b0 && irq_done == 1'b0, "R1 irqs", {irq_empty, irq_done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(txd == 1'b1 && flag_empty == 1'b1, "R1 after release", {txd, flag_empty}, 3);

      // R9 gating of the empty request while empty
      for (int g = 0; g < 4; g++) begin
         ie_empty = g[0];
         gie = g[1];
         #1;
         chk(irq_empty == (g == 3), "R9 irq_empty gating", irq_empty, (g == 3));
      end

      // R2/R4/R7: all byte values back to back, 8-bit, one tick per clock
      tx_en = 1'b1;
      gap_chk_en = 1;
      have_prev = 0;
      gap_ok = 0;
      gap_bad = 0;
      watch_done = 1;
      for (int v = 0; v < 256; v++) begin
         wait_empty();
         write_char(8'(v), 1'b0);
         chk(flag_empty == 1'b0 || v == 0, "R4 write clears empty", flag_empty, 0);
      end
      wait_empty();
      watch_done = 0;
      chk(done_seen == 0, "R7 done stays clear between back-to-back", done_seen, 0);
      wait_rx(256);
      chk(rx_count == 256, "R2 all bytes received", rx_count, 256);
      chk(gap_ok == 255 && gap_bad == 0, "R4 back-to-back spacing", gap_ok, 255);
      gap_chk_en = 0;
      wait_done();
      chk(flag_done == 1'b1, "R7 done after last stop", flag_done, 1);
      chk(txd == 1'b1, "R2 idle high after frame", txd, 1);

      // R10 gating of the done request
      for (int g = 0; g < 4; g++) begin
         ie_done = g[0];
         gie = g[1];
         #1;
         chk(irq_done == (g == 3), "R10 irq_done gating", irq_done, (g == 3));
      end
      // R8 clear pulse
      @(negedge clk);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk(flag_done == 1'b0, "R8 done_clr clears flag", flag_done, 0);
      chk(irq_done == 1'b0, "R10 irq_done follows flag", irq_done, 0);

      // R3 nine-bit frames, both ninth-bit values
      mode9 = 1'b1;
      for (int v = 0; v < 32; v++) begin
         for (int b = 0; b < 2; b++) begin
            wait_empty();
            write_char(8'(v * 7 + 3), b[0]);
         end
      end
      wait_rx(256 + 64);
      chk(rx_count == 320, "R3 nine-bit frame count", rx_count, 320);
      wait_done();

      // R11 sparse ticks: one tick every three clocks
      @(negedge clk);
      tick_div = 3;
      gap_chk_en = 1;
      have_prev = 0;
      gap_ok = 0;
      gap_bad = 0;
      for (int v = 0; v < 4; v++) begin
         wait_empty();
         write_char(8'(8'hC3 ^ 8'(v)), v[0]);
      end
      wait_rx(324);
      chk(gap_ok == 3 && gap_bad == 0, "R11 frame length scales with ticks", gap_ok, 3);
      gap_chk_en = 0;
      wait_done();
      @(negedge clk);
      tick_div = 1;
      mode9 = 1'b0;
      repeat (4) @(negedge clk);

      // R5 deferred disable: one shifting, one waiting, then tx_en dropped
      write_char(8'hA5, 1'b0);
      wait_empty();
      write_char(8'h3C, 1'b0);
      @(negedge clk);
      tx_en = 1'b0;
      chk(flag_empty == 1'b0, "R5 second char pending at disable", flag_empty, 0);
      wait_rx(326);
      chk(rx_count == 326, "R5 both chars sent after disable", rx_count, 326);
      wait_done();
      chk(flag_done == 1'b1, "R7 done after drain", flag_done, 1);

      // R6 write while disabled is held
      write_char(8'h5A, 1'b0);
      repeat (400) @(negedge clk);
      chk(rx_count == 326, "R6 nothing sent while disabled", rx_count, 326);
      chk(txd == 1'b1, "R6 line idle while disabled", txd, 1);
      chk(flag_empty == 1'b0, "R6 char still held", flag_empty, 0);
      chk(flag_done == 1'b0, "R8 write clears done", flag_done, 0);
      tx_en = 1'b1;
      wait_rx(327);
      chk(rx_count == 327, "R6 held char sent on enable", rx_count, 327);
      wait_done();
      chk(flag_done == 1'b1, "R7 done after held char", flag_done, 1);
      write_char(8'h0F, 1'b0);
      chk(flag_done == 1'b0, "R8 data write clears done", flag_done, 0);
      wait_rx(328);
      wait_done();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc > 190000);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule